// File: doc/BRIEF.md
# Potentiometer Wiper and Retained-Setting Controller

This block is the register and sequencing core behind a 128-position digitally controlled potentiometer. It keeps the live tap code in a volatile wiper register, a retained start-up setting in a register that survives a warm reset, and a small control register. The control register selects whether address 0 reaches the retained setting or only the live wiper. It also carries a software shutdown bit and a read-only busy flag. A write to the retained setting moves the wiper at once. A self-timed commit interval then starts at the transaction's end, and while it runs further wiper and control writes are refused.

After reset the tap sits at midscale (40h). Once the supply-good input has stayed high for a fixed number of cycles, the retained setting is copied into the wiper and the ready output rises. The shutdown output is active when the active-low shutdown pin is low or the shutdown bit is clear. The tap code is held through shutdown, so the same position returns on release. A serial front end drives the simple register port: a one-cycle write strobe, an address, write data, a combinational read data bus, and an end-of-transaction strobe.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: After reset the tap output is 40h and ready is 0. The control register at address 2 reads 40h: select bit 7 = 0, shutdown bit 6 = 1, busy bit 5 = 0.
- R2: Ready rises on the RECALL_CYCLES-th consecutive clock edge with supply-good high, and the tap then equals the retained setting. A low supply-good restarts the count. Writes made before ready have no effect, and the tap holds 40h until ready.
- R3: With select bit 7 = 1, a write to address 0 sets the tap to data bits 6:0 on the next clock edge. Data bit 7 is ignored, and address 0 reads back {0, tap}. Such writes never set the busy bit.
- R4: With select bit 7 = 0, a write to address 0 sets the tap as in R3 and arms a commit. The next end-of-transaction strobe sets the busy bit for exactly COMMIT_CYCLES cycles, and at the end of that interval the retained setting takes the written value. A strobe with no armed commit leaves busy at 0.
- R5: While the busy bit is 1, writes to address 0 and to address 2 have no effect.
- R6: Control register bits 4:0 read 0 and ignore writes, and bit 5 ignores writes. Addresses 1 and 3 read 0, and writes to them change nothing.
- R7: The shutdown output is 1 when the shutdown pin is low or the shutdown bit is 0, and 0 only when both are 1. The tap code is unchanged while in shutdown and after leaving it.
- R8: A committed retained setting survives a warm reset: after reset the tap is 40h, and after recall it equals the last committed value.
- R9: With select bit 7 = 0, address 0 reads {0, retained setting}, and after a commit it returns the committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good_i | input | 1 | Supply adequate for recall |
| shdn_n_i | input | 1 | Active-low shutdown pin |
| acc_wr_i | input | 1 | Register write strobe |
| acc_addr_i | input | 2 | Register address |
| acc_wdata_i | input | 8 | Write data |
| acc_stop_i | input | 1 | End-of-transaction strobe, starts an armed commit |
| acc_rdata_o | output | 8 | Read data for acc_addr_i |
| tap_o | output | 7 | Tap code, 00h nearest ground, 7Fh nearest supply |
| shutdown_o | output | 1 | Potentiometer in shutdown |
| ready_o | output | 1 | Power-up recall complete |

## Verification
Several rules are checked by assertions on every cycle. The tap holds midscale until ready, ready never falls without a reset, and neither the wiper nor the control bits move while busy. Busy only rises on an end-of-transaction strobe, only a write with select bit 0 arms a commit, and a low pin always forces shutdown. Some behaviour can only be shown by the bench's scenarios: the exact length of the recall and commit intervals, retention across a warm reset, the sweep of every tap code, the full pin and bit truth table, and the read masking of reserved bits and addresses.

// File: rtl/wnv_pkg.sv
// Shared address map and control-register bit positions for the wiper controller.
package wnv_pkg;
    localparam int ADDR_W       = 2;
    localparam int DATA_W       = 8;
    localparam logic [ADDR_W-1:0] ADDR_WIPER = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd2;
    localparam int CTRL_SEL_BIT = 7;   // 1: address 0 reaches the live wiper only
    localparam int CTRL_SD_BIT  = 6;   // 0: software shutdown
    localparam int CTRL_BSY_BIT = 5;   // read-only commit busy
endpackage

// File: rtl/wnv_recall.sv
// Power-up recall sequencer.
// Counts consecutive cycles with supply-good high. On the RECALL_CYCLES-th
// such edge it pulses load_o and sets ready_o, which then holds until reset.
// Assumes RECALL_CYCLES >= 1.
module wnv_recall #(
    parameter int RECALL_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good_i,
    output logic load_o,
    output logic ready_o
);
    localparam int CNT_W = (RECALL_CYCLES > 1) ? $clog2(RECALL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RECALL_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             ready_q;

    // Load pulse on the final counted edge.
    assign load_o  = !ready_q && pwr_good_i && (cnt_q == LAST);
    assign ready_o = ready_q;

    // Count supply-good cycles, restart on a drop, latch ready at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (!ready_q) begin
            if (!pwr_good_i) begin
                cnt_q <= '0;
            end else if (load_o) begin
                ready_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> ready_q);
endmodule

// File: rtl/wnv_commit.sv
// Self-timed commit interval timer.
// start_i opens a busy window of exactly COMMIT_CYCLES cycles. done_o pulses
// on the last busy cycle, which is when the retained register captures.
// Assumes start_i is only raised while idle.
module wnv_commit #(
    parameter int COMMIT_CYCLES = 4_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == LAST);

    // Run the busy window and close it after the programmed count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (done_o) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end
    end

    // R4
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start_i) |=> !busy_q);
endmodule

// File: rtl/wnv_regfile.sv
// Wiper, retained setting and control register with access routing.
// Writes need ready and no commit in progress. Address 0 goes to the retained
// setting (which also moves the wiper) or to the wiper alone, picked by the
// select bit. The retained register has no reset and keeps its contents across
// a warm reset; its power-on contents come from IVR_INIT.
module wnv_regfile
    import wnv_pkg::*;
#(
    parameter int               TAP_W    = 7,
    parameter logic [TAP_W-1:0] IVR_INIT = 7'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_i,
    input  logic              load_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              stop_i,
    output logic              start_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [TAP_W-1:0]  wiper_o,
    output logic              sd_bit_o
);
    localparam logic [TAP_W-1:0] MID = TAP_W'(1 << (TAP_W - 1));
    localparam int PAD_W = DATA_W - TAP_W;

    logic [TAP_W-1:0] wiper_q;
    logic [TAP_W-1:0] ivr_q = IVR_INIT;
    logic [TAP_W-1:0] pend_q;
    logic             arm_q;
    logic             sel_q;
    logic             sd_q;
    logic             wr_ok;
    logic             wr_tap;
    logic             wr_ctrl;

    assign wr_ok   = wr_i && ready_i && !busy_i;
    assign wr_tap  = wr_ok && (addr_i == ADDR_WIPER);
    assign wr_ctrl = wr_ok && (addr_i == ADDR_CTRL);
    assign start_o = stop_i && arm_q && !busy_i;
    assign wiper_o = wiper_q;
    assign sd_bit_o = sd_q;

    // Live wiper: midscale on reset, recall on load, then bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper_q <= MID;
        end else if (load_i) begin
            wiper_q <= ivr_q;
        end else if (wr_tap) begin
            wiper_q <= wdata_i[TAP_W-1:0];
        end
    end

    // Control bits: select and software shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            sd_q  <= 1'b1;
        end else if (wr_ctrl) begin
            sel_q <= wdata_i[CTRL_SEL_BIT];
            sd_q  <= wdata_i[CTRL_SD_BIT];
        end
    end

    // Commit staging: a retained-setting write arms, the end strobe disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q  <= 1'b0;
            pend_q <= '0;
        end else begin
            if (stop_i) begin
                arm_q <= 1'b0;
            end
            if (wr_tap && !sel_q) begin
                arm_q  <= 1'b1;
                pend_q <= wdata_i[TAP_W-1:0];
            end
        end
    end

    // Retained setting captures at the end of the commit interval.
    always_ff @(posedge clk) begin
        if (done_i) begin
            ivr_q <= pend_q;
        end
    end

    // Read routing by address and select bit.
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_WIPER) begin
            rdata_o = {{PAD_W{1'b0}}, (sel_q ? wiper_q : ivr_q)};
        end else if (addr_i == ADDR_CTRL) begin
            rdata_o[CTRL_SEL_BIT] = sel_q;
            rdata_o[CTRL_SD_BIT]  = sd_q;
            rdata_o[CTRL_BSY_BIT] = busy_i;
        end
    end

    // R2
    preset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |-> (wiper_q == MID));
    // R5
    busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && wr_i) |=> ($stable(wiper_q) && $stable(sel_q) && $stable(sd_q)));
    // R4
    vol_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm_q) |-> !$past(sel_q));
endmodule

// File: rtl/wiper_nv_ctrl.sv
// Top of the potentiometer wiper controller.
// Wires the recall sequencer, the commit timer and the register file, and
// combines the shutdown pin with the shutdown bit. Assumes a synchronous
// front end that issues one-cycle write and end-of-transaction strobes.
module wiper_nv_ctrl
    import wnv_pkg::*;
#(
    parameter int               TAP_W         = 7,
    parameter int               RECALL_CYCLES = 64,
    parameter int               COMMIT_CYCLES = 4_000_000,
    parameter logic [TAP_W-1:0] IVR_INIT      = 7'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good_i,
    input  logic              shdn_n_i,
    input  logic              acc_wr_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [DATA_W-1:0] acc_wdata_i,
    input  logic              acc_stop_i,
    output logic [DATA_W-1:0] acc_rdata_o,
    output logic [TAP_W-1:0]  tap_o,
    output logic              shutdown_o,
    output logic              ready_o
);
    logic load;
    logic ready;
    logic busy;
    logic done;
    logic start;
    logic sd_bit;

    wnv_recall #(.RECALL_CYCLES(RECALL_CYCLES)) recall_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good_i (pwr_good_i),
        .load_o     (load),
        .ready_o    (ready)
    );

    wnv_commit #(.COMMIT_CYCLES(COMMIT_CYCLES)) commit_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .done_o  (done)
    );

    wnv_regfile #(.TAP_W(TAP_W), .IVR_INIT(IVR_INIT)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready_i  (ready),
        .load_i   (load),
        .busy_i   (busy),
        .done_i   (done),
        .wr_i     (acc_wr_i),
        .addr_i   (acc_addr_i),
        .wdata_i  (acc_wdata_i),
        .stop_i   (acc_stop_i),
        .start_o  (start),
        .rdata_o  (acc_rdata_o),
        .wiper_o  (tap_o),
        .sd_bit_o (sd_bit)
    );

    assign ready_o    = ready;
    assign shutdown_o = !(shdn_n_i && sd_bit);

    // R7
    pin_forces_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n_i |-> shutdown_o);
endmodule

// File: tb/wiper_nv_ctrl_tb_top.sv
`timescale 1ns/1ps
module wiper_nv_ctrl_tb_top;
    localparam int RC = 8;
    localparam int CC = 16;
    localparam logic [6:0] INIT = 7'h20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic       shdn_n = 1'b1;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic       stop = 1'b0;
    logic [7:0] rdata;
    logic [6:0] tap;
    logic       sd;
    logic       ready;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wiper_nv_ctrl #(.RECALL_CYCLES(RC), .COMMIT_CYCLES(CC), .IVR_INIT(INIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good), .shdn_n_i(shdn_n),
        .acc_wr_i(wr), .acc_addr_i(addr), .acc_wdata_i(wdata), .acc_stop_i(stop),
        .acc_rdata_o(rdata), .tap_o(tap), .shutdown_o(sd), .ready_o(ready)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #0.1;
        d = rdata;
    endtask

    task automatic end_txn();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    initial begin
        logic [7:0] rv;
        logic [6:0] last;
        logic [6:0] nv_vals [3];
        nv_vals[0] = 7'h05; nv_vals[1] = 7'h7A; nv_vals[2] = 7'h33;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tap", tap, 8'h40);
        check("R1 ready", ready, 0);
        check("R1 shutdown", sd, 0);
        rd_reg(2'd2, rv);
        check("R1 ctrl", rv, 8'h40);

        // R2 writes before ready ignored
        wr_reg(2'd2, 8'h80);
        wr_reg(2'd0, 8'h11);
        check("R2 tap before ready", tap, 8'h40);

        // R2 interrupted supply-good restarts the count
        pwr_good = 1'b1;
        repeat (3) @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        pwr_good = 1'b1;
        repeat (RC - 1) @(negedge clk);
        check("R2 ready not yet", ready, 0);
        check("R2 tap midscale", tap, 8'h40);
        @(negedge clk);
        check("R2 ready", ready, 1);
        check("R2 recalled tap", tap, INIT);
        rd_reg(2'd2, rv);
        check("R2 early ctrl write ignored", rv, 8'h40);
        // R9 read of retained setting
        rd_reg(2'd0, rv);
        check("R9 retained read", rv, INIT);

        // R3 sweep of all codes on the live wiper, bit 7 set in data
        wr_reg(2'd2, 8'hC0);
        for (int c = 0; c < 128; c++) begin
            wr_reg(2'd0, 8'(c) | 8'h80);
            check("R3 tap", tap, c);
            rd_reg(2'd0, rv);
            check("R3 readback", rv, c);
        end
        end_txn();
        rd_reg(2'd2, rv);
        check("R3 R4 no busy after volatile", rv, 8'hC0);
        last = tap;

        // R6 reserved addresses and bits
        for (int a = 1; a < 4; a += 2) begin
            wr_reg(2'(a), 8'hFF);
            rd_reg(2'(a), rv);
            check("R6 reserved addr", rv, 0);
        end
        check("R6 tap untouched", tap, last);
        wr_reg(2'd2, 8'hFF);
        rd_reg(2'd2, rv);
        check("R6 ctrl low bits", rv, 8'hC0);

        // R7 pin and bit truth table
        for (int p = 0; p < 2; p++) begin
            for (int b = 0; b < 2; b++) begin
                wr_reg(2'd2, b ? 8'hC0 : 8'h80);
                shdn_n = 1'(p);
                #0.1;
                check("R7 shutdown", sd, (p == 1 && b == 1) ? 0 : 1);
                check("R7 tap held", tap, last);
            end
        end
        check("R7 tap resumed", tap, last);

        // R4 R5 R9 commit sequences
        wr_reg(2'd2, 8'h40);
        for (int i = 0; i < 3; i++) begin
            wr_reg(2'd0, {1'b0, nv_vals[i]});
            check("R4 tap follows", tap, nv_vals[i]);
            end_txn();
            wr_reg(2'd0, {1'b0, ~nv_vals[i]});
            wr_reg(2'd2, 8'h80);
            check("R5 tap locked", tap, nv_vals[i]);
            rd_reg(2'd2, rv);
            check("R5 ctrl locked busy", rv, 8'h60);
            repeat (CC - 3) @(negedge clk);
            rd_reg(2'd2, rv);
            check("R4 busy last cycle", rv, 8'h60);
            @(negedge clk);
            rd_reg(2'd2, rv);
            check("R4 busy cleared", rv, 8'h40);
            rd_reg(2'd0, rv);
            check("R9 committed", rv, nv_vals[i]);
        end

        // R8 retention across warm reset
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        check("R8 tap midscale", tap, 8'h40);
        repeat (RC - 1) @(negedge clk);
        check("R8 ready not yet", ready, 0);
        @(negedge clk);
        check("R8 ready", ready, 1);
        check("R8 retained tap", tap, nv_vals[2]);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule